// File: doc/BRIEF.md
# Conversion Result Byte-Pair Read Port

This block keeps the most recent 10-bit conversion result and lets a processor read it as two byte-wide, read-only registers at adjacent addresses. The low byte sits at 0x78 and the high byte at 0x79. A presentation bit chooses how the 10 bits sit in those 16. In right-aligned mode the result fills the low byte and the bottom two bits of the high byte. In left-aligned mode the top eight result bits fill the high byte, so software that needs only 8 bits can read that one register.

A full-precision read reads the low byte first and then the high byte. Reading the low byte sets a lock. While the lock is set, finished conversions are placed in a one-entry pending slot and do not change what the processor sees. The high-byte read clears the lock. On the next cycle the pending result, if there is one, becomes visible. The stored value is always kept unaligned, and the alignment is applied on the read path.

Results arrive on a valid/ready stream. `res_ready` is held high at all times, so a producer never stalls. A beat delivered while the lock is set replaces whatever is already in the pending slot. Only the newest unread result survives.

Top module: `adcrd_result_if`

## Requirements
- R1: After reset, both result registers read 0x00 and the alignment is taken from `align_left` (0 = right-aligned).
- R2: With `align_left`=0, a read of 0x78 returns result bits 7:0. A read of 0x79 returns bits 9:8 in its bits 1:0, and its bits 7:2 read as zero.
- R3: With `align_left`=1, a read of 0x79 returns result bits 9:2. A read of 0x78 returns bits 1:0 in its bits 7:6, and its bits 5:0 read as zero.
- R4: After a read of 0x78, results accepted before the next read of 0x79 do not change either visible byte. That 0x79 read returns the byte belonging to the older result.
- R5: A result held back by the lock becomes visible on the edge one cycle after the releasing 0x79 read. A read made in the cycle right after that release still shows the old result.
- R6: When several results arrive while locked, only the last one becomes visible after the release.
- R7: A read of 0x79 while no lock is set returns data and does nothing else. A result accepted afterwards is visible on the next cycle.
- R8: Changing `align_left` changes how the stored result is presented on the next read, without a new conversion.
- R9: `rd_data` is 0x00 when `rd_en` is low or when `rd_addr` is neither 0x78 nor 0x79.
- R10: `res_ready` is always 1. An unlocked beat with `res_valid` high becomes visible on the following cycle.
- R11: A result that arrives in the same cycle as a 0x78 read does not affect the byte returned by that read. It is held pending until the lock is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A conversion result is offered this cycle |
| res_ready | output | 1 | Always 1; the result is taken whenever valid |
| res_data | input | 10 | Unaligned conversion result |
| align_left | input | 1 | 1 = left-aligned presentation, 0 = right-aligned |
| rd_en | input | 1 | Processor read strobe |
| rd_addr | input | 8 | Processor read address |
| rd_data | output | 8 | Read data, combinational from the address and stored result |

## Verification
Two functions can coincide in one cycle. The first is a result beat arriving together with a low-byte read. The second is a result beat arriving together with the releasing high-byte read. Both are provoked by driving `res_valid` and `rd_en` in the same cycle. In each case the bench requires that the byte returned in that cycle and in the next one belongs to the old result. It also requires that the new result appears exactly one cycle after the lock is gone.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;
  // which result register a bus access hits
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } adcrd_sel_e;
endpackage

// File: rtl/adcrd_decode.sv
`timescale 1ns/1ps
module adcrd_decode
  import adcrd_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  LO_ADDR = 8'h78,
  parameter logic [7:0]  HI_ADDR = 8'h79
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output adcrd_sel_e        sel
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

  always_comb begin
    sel = SEL_NONE;
    if (rd_en) begin
      if (rd_addr == LO_A)      sel = SEL_LO;
      else if (rd_addr == HI_A) sel = SEL_HI;
    end
  end
endmodule

// File: rtl/adcrd_align.sv
`timescale 1ns/1ps
module adcrd_align #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic              left,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (left) pair = {res, {PAD_W{1'b0}}};
        else      pair = {{PAD_W{1'b0}}, res};
      end
    end else begin : g_full
      always_comb pair = PAIR_W'(res);
    end
  endgenerate

  assign lo_byte = pair[BYTE_W-1:0];
  assign hi_byte = pair[PAIR_W-1:BYTE_W];
endmodule

// File: rtl/adcrd_lock.sv
`timescale 1ns/1ps
module adcrd_lock #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             lo_rd,
  input  logic             hi_rd,
  output logic [RES_W-1:0] vis,
  output logic             locked,
  output logic             pend_valid,
  output logic [RES_W-1:0] pend_data
);
  logic can_commit;

  // visible copy may only move when no pair read is open or opening
  assign can_commit = !locked && !lo_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked     <= 1'b0;
      vis        <= '0;
      pend_valid <= 1'b0;
      pend_data  <= '0;
    end else begin
      if (lo_rd)      locked <= 1'b1;
      else if (hi_rd) locked <= 1'b0;

      if (can_commit) begin
        if (res_valid) begin
          vis        <= res_data;
          pend_valid <= 1'b0;
        end else if (pend_valid) begin
          vis        <= pend_data;
          pend_valid <= 1'b0;
        end
      end else if (res_valid) begin
        pend_data  <= res_data;
        pend_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adcrd_result_if.sv
`timescale 1ns/1ps
module adcrd_result_if
  import adcrd_pkg::*;
#(
  parameter int         RES_W   = 10,
  parameter int         BYTE_W  = 8,
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] LO_ADDR = 8'h78,
  parameter logic [7:0] HI_ADDR = 8'h79
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [RES_W-1:0]  res_data,
  input  logic              align_left,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  adcrd_sel_e        sel;
  logic              lo_rd, hi_rd;
  logic [RES_W-1:0]  vis_w, pend_data_w;
  logic              locked_w, pend_valid_w;
  logic [BYTE_W-1:0] lo_byte, hi_byte;

  assign res_ready = 1'b1;

  adcrd_decode #(
    .ADDR_W (ADDR_W),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
  ) u_dec (
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .sel    (sel)
  );

  assign lo_rd = (sel == SEL_LO);
  assign hi_rd = (sel == SEL_HI);

  adcrd_lock #(.RES_W(RES_W)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_data  (res_data),
    .lo_rd     (lo_rd),
    .hi_rd     (hi_rd),
    .vis       (vis_w),
    .locked    (locked_w),
    .pend_valid(pend_valid_w),
    .pend_data (pend_data_w)
  );

  adcrd_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_align (
    .res    (vis_w),
    .left   (align_left),
    .lo_byte(lo_byte),
    .hi_byte(hi_byte)
  );

  always_comb begin
    unique case (sel)
      SEL_LO:  rd_data = lo_byte;
      SEL_HI:  rd_data = hi_byte;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/adcrd_result_if_chk.sv
`timescale 1ns/1ps
module adcrd_result_if_chk #(
  parameter int         RES_W   = 10,
  parameter int         BYTE_W  = 8,
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] LO_ADDR = 8'h78,
  parameter logic [7:0] HI_ADDR = 8'h79
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [RES_W-1:0]  res_data,
  input logic              align_left,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic [RES_W-1:0]  vis,
  input logic              locked,
  input logic              pend_valid,
  input logic [RES_W-1:0]  pend_data
);
  logic lo_hit, hi_hit;
  assign lo_hit = rd_en && (rd_addr == ADDR_W'(LO_ADDR));
  assign hi_hit = rd_en && (rd_addr == ADDR_W'(HI_ADDR));

  AST_RIGHT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_hit && !align_left) |-> (rd_data[BYTE_W-1:2] == '0)); // R2
  AST_LEFT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_hit && align_left) |-> (rd_data[5:0] == '0)); // R3
  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lo_hit |=> locked); // R4
  AST_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked || lo_hit) |=> $stable(vis)); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && hi_hit) |=> !locked); // R5
  AST_PEND_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !lo_hit && !res_valid && pend_valid) |=> (vis == $past(pend_data)) && !pend_valid); // R5
  AST_PEND_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    ((locked || lo_hit) && res_valid) |=> pend_valid && (pend_data == $past(res_data))); // R6
  AST_HI_NOLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && hi_hit) |=> !locked); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_hit && !hi_hit) |-> (rd_data == '0)); // R9
  AST_TAKE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !lo_hit && res_valid) |=> (vis == $past(res_data))); // R10
endmodule

bind adcrd_result_if adcrd_result_if_chk #(
  .RES_W  (RES_W),
  .BYTE_W (BYTE_W),
  .ADDR_W (ADDR_W),
  .LO_ADDR(LO_ADDR),
  .HI_ADDR(HI_ADDR)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_data  (res_data),
  .align_left(align_left),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .vis       (vis_w),
  .locked    (locked_w),
  .pend_valid(pend_valid_w),
  .pend_data (pend_data_w)
);

// File: tb/adcrd_result_if_tb_top.sv
`timescale 1ns/1ps
module adcrd_result_if_tb_top;
  localparam logic [7:0] A_LO = 8'h78;
  localparam logic [7:0] A_HI = 8'h79;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic       res_ready;
  logic [9:0] res_data = '0;
  logic       align_left = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adcrd_result_if dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .align_left(align_left),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  function automatic logic [7:0] want_lo(input logic [9:0] v, input logic left);
    return left ? {v[1:0], 6'b0} : v[7:0];
  endfunction
  function automatic logic [7:0] want_hi(input logic [9:0] v, input logic left);
    return left ? v[9:2] : {6'b0, v[9:8]};
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // one bus cycle: inputs held for exactly one rising edge, data sampled before it
  task automatic step(input logic v, input logic [9:0] d, input logic en,
                      input logic [7:0] a, output logic [7:0] q);
    @(negedge clk);
    res_valid = v; res_data = d; rd_en = en; rd_addr = a;
    #1 q = rd_data;
    checks++;
    if (res_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10: res_ready got %b expected 1", res_ready);
    end
    @(posedge clk);
    #1 res_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic push(input logic [9:0] d);
    logic [7:0] q;
    step(1'b1, d, 1'b0, 8'h00, q);
  endtask
  task automatic rd(input logic [7:0] a, output logic [7:0] q);
    step(1'b0, '0, 1'b1, a, q);
  endtask
  task automatic idle();
    logic [7:0] q;
    step(1'b0, '0, 1'b0, 8'h00, q);
    check("R9 idle", q, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] q;
    rd(A_LO, q); check("R1 low", q, 8'h00);
    rd(A_HI, q); check("R1 high", q, 8'h00);
  endtask

  task automatic t_right();
    logic [7:0] q;
    align_left = 1'b0;
    push(10'h2A5);
    rd(A_LO, q); check("R2 low a", q, want_lo(10'h2A5, 0));
    rd(A_HI, q); check("R2 high a", q, want_hi(10'h2A5, 0));
    push(10'h15A);
    rd(A_LO, q); check("R2 low b", q, 8'h5A);
    rd(A_HI, q); check("R2 high b", q, 8'h01);
  endtask

  task automatic t_left_and_realign();
    logic [7:0] q;
    align_left = 1'b1;
    push(10'h2A7);
    rd(A_HI, q); check("R3 high only", q, 8'hA9);
    rd(A_LO, q); check("R3 low", q, 8'hC0);
    rd(A_HI, q); check("R3 high", q, 8'hA9);
    align_left = 1'b0;
    rd(A_LO, q); check("R8 low realigned", q, 8'hA7);
    rd(A_HI, q); check("R8 high realigned", q, 8'h02);
  endtask

  task automatic t_lock();
    logic [7:0] q;
    align_left = 1'b0;
    push(10'h123);
    rd(A_LO, q);  check("R4 low", q, 8'h23);
    push(10'h3C4);
    rd(A_HI, q);  check("R4 high old", q, 8'h01);
    rd(A_HI, q);  check("R5 one cycle after release", q, 8'h01);
    rd(A_HI, q);  check("R5 new high", q, 8'h03);
    rd(A_LO, q);  check("R5 new low", q, 8'hC4);
    rd(A_HI, q);  check("R5 unlock", q, 8'h03);
  endtask

  task automatic t_overwrite();
    logic [7:0] q;
    align_left = 1'b0;
    push(10'h011);
    rd(A_LO, q);  check("R6 low", q, 8'h11);
    push(10'h222);
    push(10'h333);
    rd(A_HI, q);  check("R6 high old", q, 8'h00);
    idle();
    rd(A_LO, q);  check("R6 newest low", q, 8'h33);
    rd(A_HI, q);  check("R6 newest high", q, 8'h03);
  endtask

  task automatic t_same_cycle();
    logic [7:0] q;
    align_left = 1'b0;
    push(10'h0F0);
    step(1'b1, 10'h30F, 1'b1, A_LO, q); check("R11 low old", q, 8'hF0);
    rd(A_HI, q);  check("R11 high old", q, 8'h00);
    idle();
    rd(A_HI, q);  check("R11 high new", q, 8'h03);
    rd(A_LO, q);  check("R11 low new", q, 8'h0F);
    // beat arriving with the releasing read stays pending one more cycle
    push(10'h3FF);
    step(1'b1, 10'h000, 1'b1, A_HI, q); check("R5 release with beat old", q, 8'h03);
    rd(A_HI, q);  check("R5 release with beat next", q, 8'h03);
    rd(A_HI, q);  check("R5 release with beat new", q, 8'h00);
  endtask

  task automatic t_hi_nolock();
    logic [7:0] q;
    align_left = 1'b1;
    push(10'h0C4);
    rd(A_HI, q);  check("R7 high", q, 8'h31);
    push(10'h3F8);
    rd(A_HI, q);  check("R7 no lock from high read", q, 8'hFE);
  endtask

  task automatic t_other();
    logic [7:0] q;
    rd(8'h77, q); check("R9 addr 0x77", q, 8'h00);
    rd(8'h7A, q); check("R9 addr 0x7A", q, 8'h00);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_right();
    t_left_and_realign();
    t_lock();
    t_overwrite();
    t_same_cycle();
    t_hi_nolock();
    t_other();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule